// File: doc/BRIEF.md
# USB PHY power-up reset sequencer

This block is a hardware state machine that brings a USB PHY and the USB controller attached to it out of reset. It always uses the same order of steps, and it times every wait by counting cycles of a clock whose frequency is a parameter. A single start pulse launches the sequence. The block first holds the controller in reset and lets a settling time pass. It then releases the PHY's power-on reset and its reset together. Next it gates off the PHY configuration parallel-interface clock, switches the interface select, and ungates the clock again.

After that the block polls an SRAM-initialisation status from the PHY at a fixed interval, within a bounded time budget. Once the status reads as ready, the block raises an external-load-complete level. After a further settling time it releases the controller reset and reports completion. If the status never shows ready, the block stops in an error state and keeps the controller in reset.

Each wait lasts at least the stated number of microseconds: cycles = ceil(CLK_FREQ_HZ × µs / 10^6), with a minimum of one cycle. The SRAM status is an asynchronous input and passes through a two-stage synchroniser.

Top module: `usb_phy_pwrup_seq`

## Requirements
- R1: While reset is applied and after it is released, the outputs sit in their safe state until a start is accepted: ctl_rst_no=0, phy_por_o=1, phy_rst_o=1, cr_clk_en_o=0, cr_sel_o=0, ld_done_o=0, done_o=0, err_o=0.
- R2: start_i is accepted in the idle, done or error state. The PHY resets fall exactly N_HOLD cycles after the accepting edge, where N_HOLD is the cycle count for HOLD_US (20 µs). ctl_rst_no stays 0 throughout.
- R3: phy_por_o and phy_rst_o always hold the same value, so both fall at the same clock edge.
- R4: cr_sel_o rises exactly N_GATE cycles (GATE_US, 2 µs) after the PHY resets fall. cr_clk_en_o is 0 when cr_sel_o rises.
- R5: cr_clk_en_o rises exactly one cycle after cr_sel_o rises, and cr_sel_o stays 1.
- R6: The synchronised SRAM status is first sampled in the cycle in which cr_clk_en_o rises, and again every N_POLL cycles (POLL_US, 1 ms) after that. If sample k (k = 0, 1, …) reads 1, ld_done_o rises 1 + k·N_POLL cycles after cr_clk_en_o rises. The raw input must be 1 at the clock edge two cycles before the deciding edge.
- R7: ctl_rst_no and done_o rise exactly N_SETTLE cycles (SETTLE_US, 20 µs) after ld_done_o rises.
- R8: If samples 0 to POLL_LIMIT (default 10) all read 0, err_o rises 1 + POLL_LIMIT·N_POLL cycles after cr_clk_en_o rises. While in error, ctl_rst_no stays 0, ld_done_o stays 0 and err_o stays 1 until a new start.
- R9: A start_i pulse while a sequence is in progress has no effect: the sequence timing and the final outputs are unchanged.
- R10: On the edge that accepts a start from the done or error state, every output returns to the R1 safe values, which clears done_o and err_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock of frequency CLK_FREQ_HZ |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, one cycle |
| sram_done_i | input | 1 | Asynchronous SRAM-initialisation-complete status |
| ctl_rst_no | output | 1 | Controller reset, active low |
| phy_por_o | output | 1 | PHY power-on reset, active high |
| phy_rst_o | output | 1 | PHY reset, active high |
| cr_clk_en_o | output | 1 | Configuration parallel-interface clock enable |
| cr_sel_o | output | 1 | Configuration parallel-interface select |
| ld_done_o | output | 1 | External SRAM load complete |
| done_o | output | 1 | Sequence finished, controller released |
| err_o | output | 1 | Sticky SRAM-poll timeout flag |

## Verification
The bench builds the block with CLK_FREQ_HZ = 1 MHz and the default microsecond values. One cycle then stands for one microsecond, so the waits become 20, 2, 20 and 1000 cycles. This brings the full 10 ms timeout, and readiness on the very last permitted sample, within a short run. The same cycle formula at 125 MHz would need more than a million cycles per timeout. Random ready-sample indices in the range 0 to 11 cover immediate readiness, mid-budget readiness and timeout, and some runs add a stray start during the hold phase.

// File: rtl/usb_pwrseq_pkg.sv
package usb_pwrseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_GATE,
        ST_SEL,
        ST_POLL,
        ST_SETTLE,
        ST_DONE,
        ST_ERR
    } seq_state_e;

    typedef struct packed {
        logic ctl_rst_n;
        logic phy_por;
        logic phy_rst;
        logic cr_clk_en;
        logic cr_sel;
        logic ld_done;
        logic done;
        logic err;
    } ctl_bus_t;

    localparam ctl_bus_t SAFE_BUS = '{
        ctl_rst_n: 1'b0, phy_por: 1'b1, phy_rst: 1'b1, cr_clk_en: 1'b0,
        cr_sel: 1'b0, ld_done: 1'b0, done: 1'b0, err: 1'b0
    };

    // Rounds up so that a wait never falls short of the microsecond target.
    function automatic int unsigned us_to_cycles(input int unsigned hz,
                                                 input int unsigned us);
        longint unsigned c;
        c = (longint'(hz) * longint'(us) + 64'd999_999) / 64'd1_000_000;
        return (c == 0) ? 32'd1 : int'(c[31:0]);
    endfunction

endpackage

// File: rtl/usb_pwrseq_timer.sv
module usb_pwrseq_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/usb_pwrseq_sync.sv
module usb_pwrseq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff_d, ff_q;

    always_comb begin
        ff_d = {ff_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= ff_d;
    end

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/usb_phy_pwrup_seq.sv
module usb_phy_pwrup_seq
    import usb_pwrseq_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ = 125_000_000,
    parameter int unsigned HOLD_US     = 20,
    parameter int unsigned GATE_US     = 2,
    parameter int unsigned POLL_US     = 1000,
    parameter int unsigned POLL_LIMIT  = 10,
    parameter int unsigned SETTLE_US   = 20
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic sram_done_i,
    output logic ctl_rst_no,
    output logic phy_por_o,
    output logic phy_rst_o,
    output logic cr_clk_en_o,
    output logic cr_sel_o,
    output logic ld_done_o,
    output logic done_o,
    output logic err_o
);
    localparam int unsigned N_HOLD   = us_to_cycles(CLK_FREQ_HZ, HOLD_US);
    localparam int unsigned N_GATE   = us_to_cycles(CLK_FREQ_HZ, GATE_US);
    localparam int unsigned N_POLL   = us_to_cycles(CLK_FREQ_HZ, POLL_US);
    localparam int unsigned N_SETTLE = us_to_cycles(CLK_FREQ_HZ, SETTLE_US);
    localparam int unsigned MAX_A    = (N_HOLD > N_GATE) ? N_HOLD : N_GATE;
    localparam int unsigned MAX_B    = (N_POLL > N_SETTLE) ? N_POLL : N_SETTLE;
    localparam int unsigned MAX_N    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W    = $clog2(MAX_N + 1);
    localparam int unsigned PCNT_W   = $clog2(POLL_LIMIT + 1) + 1;

    localparam logic [CNT_W-1:0]  LD_HOLD   = CNT_W'(N_HOLD - 1);
    localparam logic [CNT_W-1:0]  LD_GATE   = CNT_W'(N_GATE - 1);
    localparam logic [CNT_W-1:0]  LD_POLL   = CNT_W'(N_POLL - 1);
    localparam logic [CNT_W-1:0]  LD_SETTLE = CNT_W'(N_SETTLE - 1);
    localparam logic [PCNT_W-1:0] LAST_POLL = PCNT_W'(POLL_LIMIT);

    typedef struct packed {
        seq_state_e        st;
        ctl_bus_t          o;
        logic [PCNT_W-1:0] pcnt;
    } seq_t;

    seq_t             s_d, s_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             sram_rdy;
    logic             can_start;

    usb_pwrseq_sync #(.STAGES(2)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (sram_done_i),
        .q_o    (sram_rdy)
    );

    usb_pwrseq_timer #(.W(CNT_W)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    assign can_start = (s_q.st == ST_IDLE) || (s_q.st == ST_DONE) ||
                       (s_q.st == ST_ERR);

    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (can_start && start_i) begin
            s_d.st   = ST_HOLD;
            s_d.o    = SAFE_BUS;
            s_d.pcnt = '0;
            tmr_load = 1'b1;
            tmr_val  = LD_HOLD;
        end else begin
            unique case (s_q.st)
                ST_HOLD: if (tmr_zero) begin
                    s_d.st          = ST_GATE;
                    s_d.o.phy_por   = 1'b0;
                    s_d.o.phy_rst   = 1'b0;
                    s_d.o.cr_clk_en = 1'b0;
                    tmr_load        = 1'b1;
                    tmr_val         = LD_GATE;
                end
                ST_GATE: if (tmr_zero) begin
                    s_d.st       = ST_SEL;
                    s_d.o.cr_sel = 1'b1;
                end
                ST_SEL: begin
                    s_d.st          = ST_POLL;
                    s_d.o.cr_clk_en = 1'b1;
                    s_d.pcnt        = '0;
                    tmr_load        = 1'b1;
                    tmr_val         = '0;
                end
                ST_POLL: if (tmr_zero) begin
                    if (sram_rdy) begin
                        s_d.st        = ST_SETTLE;
                        s_d.o.ld_done = 1'b1;
                        tmr_load      = 1'b1;
                        tmr_val       = LD_SETTLE;
                    end else if (s_q.pcnt == LAST_POLL) begin
                        s_d.st    = ST_ERR;
                        s_d.o.err = 1'b1;
                    end else begin
                        s_d.pcnt = s_q.pcnt + 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = LD_POLL;
                    end
                end
                ST_SETTLE: if (tmr_zero) begin
                    s_d.st          = ST_DONE;
                    s_d.o.ctl_rst_n = 1'b1;
                    s_d.o.done      = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{st: ST_IDLE, o: SAFE_BUS, pcnt: '0};
        else         s_q <= s_d;
    end

    assign ctl_rst_no  = s_q.o.ctl_rst_n;
    assign phy_por_o   = s_q.o.phy_por;
    assign phy_rst_o   = s_q.o.phy_rst;
    assign cr_clk_en_o = s_q.o.cr_clk_en;
    assign cr_sel_o    = s_q.o.cr_sel;
    assign ld_done_o   = s_q.o.ld_done;
    assign done_o      = s_q.o.done;
    assign err_o       = s_q.o.err;
endmodule

// File: rtl/usb_pwrseq_sva.sv
module usb_pwrseq_sva (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic ctl_rst_no,
    input logic phy_por_o,
    input logic phy_rst_o,
    input logic cr_clk_en_o,
    input logic cr_sel_o,
    input logic ld_done_o,
    input logic done_o,
    input logic err_o
);
    // R2: the PHY leaves reset only while the controller has been held in reset
    a_r2_phy_under_ctl_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(phy_rst_o) |-> (!ctl_rst_no && $past(!ctl_rst_no)));

    // R3: both PHY resets move together
    a_r3_por_tracks_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phy_por_o == phy_rst_o);

    // R4: the select only changes while the interface clock is gated
    a_r4_sel_while_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cr_sel_o) |-> !cr_clk_en_o);

    // R5: the clock returns only after the select has settled
    a_r5_ungate_after_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cr_clk_en_o) |-> (cr_sel_o && $past(cr_sel_o)));

    // R6: load-complete needs the interface selected and clocked
    a_r6_ld_after_ungate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ld_done_o) |-> (cr_clk_en_o && cr_sel_o && !phy_rst_o));

    // R7: controller release follows an earlier load-complete
    a_r7_rel_after_ld: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ctl_rst_no) |-> (ld_done_o && $past(ld_done_o) && done_o));

    // R8: the error is sticky and keeps the controller in reset
    a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_o && !start_i) |=> (err_o && !ctl_rst_no && !ld_done_o));

    // R1: done and error never coexist
    a_r1_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && err_o));
endmodule

bind usb_phy_pwrup_seq usb_pwrseq_sva u_sva (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .ctl_rst_no  (ctl_rst_no),
    .phy_por_o   (phy_por_o),
    .phy_rst_o   (phy_rst_o),
    .cr_clk_en_o (cr_clk_en_o),
    .cr_sel_o    (cr_sel_o),
    .ld_done_o   (ld_done_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/usb_phy_pwrup_seq_bench.sv
`timescale 1ns/1ps
module usb_phy_pwrup_seq_bench;
    // 1 MHz nominal: one cycle per microsecond
    localparam int N_HOLD = 20, N_GATE = 2, N_SETTLE = 20, N_POLL = 1000, LIM = 10;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sram_done = 1'b0;
    logic ctl_rst_n, phy_por, phy_rst, clk_en, sel, ld, done, err;
    int cyc = 0, checks = 0, fails = 0;
    int t_phy, t_por, t_sel, t_clk, t_ld, t_rel, t_err;
    logic p_phy, p_por, p_sel, p_clk, p_ld, p_rel, p_err;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    usb_phy_pwrup_seq #(.CLK_FREQ_HZ(1_000_000)) u_usb_phy_pwrup_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sram_done_i(sram_done),
        .ctl_rst_no(ctl_rst_n), .phy_por_o(phy_por), .phy_rst_o(phy_rst),
        .cr_clk_en_o(clk_en), .cr_sel_o(sel), .ld_done_o(ld),
        .done_o(done), .err_o(err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_phy && !phy_rst) t_phy = cyc;
            if (p_por && !phy_por) t_por = cyc;
            if (!p_sel && sel) t_sel = cyc;
            if (!p_clk && clk_en) t_clk = cyc;
            if (!p_ld && ld) t_ld = cyc;
            if (!p_rel && ctl_rst_n) t_rel = cyc;
            if (!p_err && err) t_err = cyc;
        end
        p_phy = phy_rst; p_por = phy_por; p_sel = sel; p_clk = clk_en;
        p_ld = ld; p_rel = ctl_rst_n; p_err = err;
    end

    function automatic int exp_ld_delay(input int k);
        return 1 + k * N_POLL;
    endfunction

    function automatic int exp_err_delay();
        return 1 + LIM * N_POLL;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_safe(input string req);
        logic [7:0] v;
        v = {ctl_rst_n, phy_por, phy_rst, clk_en, sel, ld, done, err};
        check(v == 8'b0110_0000, req, int'(v), 8'b0110_0000);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // k: index of the first ready sample; k > LIM means never ready
    task automatic run_seq(input int k, input bit inject);
        int ts;
        sram_done = (k == 0);
        t_phy = -1; t_por = -1; t_sel = -1; t_clk = -1;
        t_ld = -1; t_rel = -1; t_err = -1;
        pulse_start();
        ts = cyc;
        check_safe("R10 restart safe");
        if (inject) begin
            repeat ($urandom_range(1, 15)) @(negedge clk);
            pulse_start();
        end
        while (t_clk < 0) @(negedge clk);
        if (k >= 1 && k <= LIM) begin
            while (cyc < t_clk + k * N_POLL - N_POLL / 2) @(negedge clk);
            sram_done = 1'b1;
        end
        while (!done && !err) @(negedge clk);
        @(negedge clk);
        check(t_phy - ts == N_HOLD, inject ? "R9 R2 hold" : "R2 hold", t_phy - ts, N_HOLD);
        check(t_por == t_phy, "R3 por with rst", t_por, t_phy);
        check(t_sel - t_phy == N_GATE, "R4 gate", t_sel - t_phy, N_GATE);
        check(t_clk - t_sel == 1, "R5 ungate", t_clk - t_sel, 1);
        if (k <= LIM) begin
            check(t_ld - t_clk == exp_ld_delay(k), "R6 poll", t_ld - t_clk, exp_ld_delay(k));
            check(t_rel - t_ld == N_SETTLE, "R7 settle", t_rel - t_ld, N_SETTLE);
            check(done && ctl_rst_n && !err, inject ? "R9 R7 done" : "R7 done", int'(done), 1);
        end else begin
            check(t_err - t_clk == exp_err_delay(), "R8 timeout", t_err - t_clk, exp_err_delay());
            repeat (50) @(negedge clk);
            check(err && !ctl_rst_n && !ld && !done, "R8 sticky", int'(err), 1);
        end
    endtask

    initial begin
        repeat (190_000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        check_safe("R1 in reset");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_safe("R1 after reset");
        run_seq(0, 1'b0);
        run_seq(3, 1'b1);
        run_seq(LIM + 1, 1'b0);
        run_seq(LIM, 1'b0);
        for (int i = 0; i < 6; i++) begin
            run_seq($urandom_range(0, LIM + 1), 1'($urandom_range(0, 1)));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule